// File: doc/BRIEF.md
# Set/Reset Macrocell State Machine

This block models a small programmable-array output stage and a two-bit state machine built from it. Each output cell holds a stored bit. That bit is written on the clock edge from a pair of sum-of-products terms, one that sets it and one that clears it. A per-cell select decides whether the cell's pin shows the stored bit or the value the cell will load at the next edge. A per-cell enable forces the pin low when it is off. The stored bit always feeds back into the product-term array, whatever the select and enable settings are.

Two such cells hold state bits y1 (cell index 0) and y2 (cell index 1). The machine has two primary inputs, P and Q, and one Mealy output, Z. Excitation terms:
- y1 is set by P'·Q' and cleared by P + Q.
- y2 is set by P'·Q·y1 and cleared by y2.
- Z = y2·y1'·P·Q'.

Reset is asserted asynchronously and active-low, and it is released synchronously through a two-stage synchronizer.

Top module: `pal_sr_fsm`

## Requirements
- R1: After each rising edge, y1 (cell index 0) is 1 when P=0 and Q=0 held before the edge, and 0 otherwise.
- R2: After each rising edge, y2 (cell index 1) takes the value of P'·Q·y1 sampled before the edge. When y2=1 and that term is 0, the clear term y2 resets it.
- R3: A cell whose set and clear terms are both 1 at an edge keeps its stored bit.
- R4: A cell with only set at 1 stores 1, with only clear at 1 stores 0, and with neither keeps its bit.
- R5: z_out equals y2·y1'·P·Q' combinationally while z_oe=1, and is 0 while z_oe=0.
- R6: With cell_sel[i]=1, cell_pin[i] shows the stored bit. With cell_sel[i]=0, it shows the value the cell will store at the next edge.
- R7: With cell_oe[i]=0, cell_pin[i] is 0. The stored bits and the feedback keep evolving, and they are visible again as soon as the enable returns.
- R8: rst_n=0 clears both state bits at once. After rst_n rises at a falling edge, the state stays 0 through the next two rising edges and follows R1/R2 from the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_p | input | 1 | Primary input P |
| in_q | input | 1 | Primary input Q |
| cell_sel | input | 2 | Per-cell select: 1 = stored bit, 0 = next value; bit 0 = y1, bit 1 = y2 |
| cell_oe | input | 2 | Per-cell output enable, bit order as cell_sel |
| z_oe | input | 1 | Enable for z_out |
| cell_pin | output | 2 | Cell pins, bit 0 = y1, bit 1 = y2 |
| z_out | output | 1 | Mealy output Z |

## Verification
The assertions assume that in_p and in_q are steady around each rising edge. They also assume the state only ever starts from the reset value. From reset, the pair y2=1, y1=1 cannot be reached, so at the top the set and clear terms of y2 never rise together. For that reason the hold case of R3 is driven on a separate instance of the cell with its set and clear inputs wired to the bench. All other stimulus changes on the falling edge. It walks every input sequence of length four from reset and compares each step against a set/reset model kept in the bench.

// File: rtl/pal_fsm_pkg.sv
package pal_fsm_pkg;
  localparam int unsigned N_STATE = 2;
  localparam int unsigned IDX_Y1  = 0;
  localparam int unsigned IDX_Y2  = 1;

  typedef struct packed {
    logic set;
    logic clr;
  } sr_exc_t;
endpackage

// File: rtl/pal_rst_sync.sv
module pal_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_r <= '0;
    else        sh_r <= {sh_r[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_r[STAGES-1];
endmodule

// File: rtl/pal_and_or_plane.sv
module pal_and_or_plane
  import pal_fsm_pkg::*;
(
  input  logic                          in_p,
  input  logic                          in_q,
  input  logic [N_STATE-1:0]            fb_i,
  output sr_exc_t [N_STATE-1:0]         exc_o,
  output logic                          z_o
);
  localparam int unsigned N_PT = 6;

  logic [N_PT-1:0] pt;
  logic y1, y2;

  assign y1 = fb_i[IDX_Y1];
  assign y2 = fb_i[IDX_Y2];

  // product-term array
  always_comb begin
    pt[0] = ~in_p &  in_q & y1;          // sets y2
    pt[1] =  y2;                          // clears y2
    pt[2] = ~in_p & ~in_q;                // sets y1
    pt[3] =  in_q;                        // clears y1 (part)
    pt[4] =  in_p;                        // clears y1 (part)
    pt[5] =  y2 & ~y1 & in_p & ~in_q;     // output term
  end

  // fixed sum array
  always_comb begin
    exc_o[IDX_Y2].set = pt[0];
    exc_o[IDX_Y2].clr = pt[1];
    exc_o[IDX_Y1].set = pt[2];
    exc_o[IDX_Y1].clr = pt[3] | pt[4];
    z_o               = pt[5];
  end
endmodule

// File: rtl/pal_sr_cell.sv
module pal_sr_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic sel_i,
  input  logic oe_i,
  output logic q_o,
  output logic pin_o
);
  logic q_r;
  logic load_en;
  logic q_next;

  // only one active term changes the bit; both or neither hold it
  always_comb begin
    load_en = set_i ^ clr_i;
    q_next  = load_en ? set_i : q_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q_r <= 1'b0;
    else if (load_en) q_r <= set_i;
  end

  assign q_o   = q_r;
  assign pin_o = oe_i & (sel_i ? q_r : q_next);

  p_both_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && clr_i) |=> (q_r == $past(q_r)));
  p_set_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !clr_i) |=> q_r);
  p_clr_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_r);
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(q_r));
endmodule

// File: rtl/pal_sr_fsm.sv
module pal_sr_fsm
  import pal_fsm_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_p,
  input  logic               in_q,
  input  logic [N_STATE-1:0] cell_sel,
  input  logic [N_STATE-1:0] cell_oe,
  input  logic               z_oe,
  output logic [N_STATE-1:0] cell_pin,
  output logic               z_out
);
  logic                  rst_sync_n;
  logic [N_STATE-1:0]    fb;
  sr_exc_t [N_STATE-1:0] exc;
  logic                  z_sop;

  pal_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pal_and_or_plane u_plane (
    .in_p  (in_p),
    .in_q  (in_q),
    .fb_i  (fb),
    .exc_o (exc),
    .z_o   (z_sop)
  );

  for (genvar g = 0; g < N_STATE; g++) begin : g_cell
    pal_sr_cell u_cell (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .set_i (exc[g].set),
      .clr_i (exc[g].clr),
      .sel_i (cell_sel[g]),
      .oe_i  (cell_oe[g]),
      .q_o   (fb[g]),
      .pin_o (cell_pin[g])
    );
  end

  assign z_out = z_oe & z_sop;

  p_y1_set_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!in_p && !in_q) |=> fb[IDX_Y1]);
  p_y1_clr_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_p || in_q) |=> !fb[IDX_Y1]);
  p_y2_set_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!in_p && in_q && fb[IDX_Y1]) |=> fb[IDX_Y2]);
  p_y2_clr_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_p || !in_q || !fb[IDX_Y1]) |=> !fb[IDX_Y2]);
  p_z_state_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    z_out |-> (z_oe && fb[IDX_Y2] && !fb[IDX_Y1]));
endmodule

// File: tb/test_pal_sr_fsm.sv
module test_pal_sr_fsm;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_p, in_q, z_oe;
  logic [1:0] cell_sel, cell_oe, cell_pin;
  logic       z_out;
  logic       c_set, c_clr, c_sel, c_oe, c_q, c_pin;
  int         n_tests = 0;
  int         n_fail  = 0;
  logic [1:0] model_y;

  always #4 clk = ~clk;

  pal_sr_fsm i_pal_sr_fsm (
    .clk(clk), .rst_n(rst_n), .in_p(in_p), .in_q(in_q),
    .cell_sel(cell_sel), .cell_oe(cell_oe), .z_oe(z_oe),
    .cell_pin(cell_pin), .z_out(z_out)
  );

  pal_sr_cell i_cell (
    .clk(clk), .rst_n(rst_n), .set_i(c_set), .clr_i(c_clr),
    .sel_i(c_sel), .oe_i(c_oe), .q_o(c_q), .pin_o(c_pin)
  );

  // {P, Q, Z before edge, y2 after, y1 after}
  localparam logic [4:0] VEC [17] = '{
    5'b00_0_01, 5'b01_0_10, 5'b10_1_00, 5'b00_0_01, 5'b11_0_00,
    5'b01_0_00, 5'b00_0_01, 5'b10_0_00, 5'b00_0_01, 5'b01_0_10,
    5'b00_0_01, 5'b01_0_10, 5'b11_0_00, 5'b00_0_01, 5'b00_0_01,
    5'b01_0_10, 5'b01_0_00
  };

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step(input logic p, input logic q, input logic ez,
                      input logic [1:0] ey, input string req);
    @(negedge clk);
    in_p = p; in_q = q;
    #1 check({req, " z"}, {1'b0, z_out}, {1'b0, ez});
    @(posedge clk);
    #1 check({req, " state"}, cell_pin, ey);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_p = 1'b1; in_q = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_p = 1'b1; in_q = 1'b1; z_oe = 1'b1;
    cell_sel = 2'b11; cell_oe = 2'b11;
    c_set = 1'b0; c_clr = 1'b0; c_sel = 1'b1; c_oe = 1'b1;
    #2 check("R8 reset state", cell_pin, 2'b00);
    do_reset();

    // table walk: R1, R2, R5
    for (int i = 0; i < 17; i++)
      step(VEC[i][4], VEC[i][3], VEC[i][2], VEC[i][1:0], "R1/R2/R5 table");

    // exhaustive depth-4 sequences against an SR model
    for (int s = 0; s < 256; s++) begin
      do_reset();
      model_y = 2'b00;
      for (int d = 0; d < 4; d++) begin
        logic p, q, ez;
        logic [1:0] nxt;
        p  = s[2*d+1];
        q  = s[2*d];
        ez = model_y[1] & ~model_y[0] & p & ~q;
        nxt[0] = (~p & ~q) ? 1'b1 : 1'b0;
        nxt[1] = (~p & q & model_y[0]) ? 1'b1 : (model_y[1] ? 1'b0 : model_y[1]);
        step(p, q, ez, nxt, "R1/R2/R5 sweep");
        model_y = nxt;
      end
    end

    // R6: select shows next value versus stored value
    do_reset();
    @(negedge clk);
    in_p = 1'b0; in_q = 1'b0; cell_sel = 2'b00;
    #1 check("R6 sel=0 next value", cell_pin, 2'b01);
    cell_sel = 2'b11;
    #1 check("R6 sel=1 stored value", cell_pin, 2'b00);
    @(posedge clk);
    #1 check("R6 stored after edge", cell_pin, 2'b01);

    // R7 and R5 gating: enables off, state still advances
    @(negedge clk);
    cell_oe = 2'b00; z_oe = 1'b0; in_p = 1'b0; in_q = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_p = 1'b1; in_q = 1'b0;
    #1 check("R7 pins off", cell_pin, 2'b00);
    check("R5 z gated off", {1'b0, z_out}, 2'b00);
    cell_oe = 2'b11; z_oe = 1'b1;
    #1 check("R7 state kept while off", cell_pin, 2'b10);
    check("R5 z on", {1'b0, z_out}, 2'b01);

    // R8: reset mid-run and synchronous release timing
    @(posedge clk);
    step(1'b0, 1'b0, 1'b0, 2'b01, "R1 pre-reset");
    @(negedge clk);
    rst_n = 1'b0;
    #1 check("R8 async clear", cell_pin, 2'b00);
    @(negedge clk);
    rst_n = 1'b1; in_p = 1'b0; in_q = 1'b0;
    @(posedge clk);
    #1 check("R8 held edge 1", cell_pin, 2'b00);
    @(posedge clk);
    #1 check("R8 held edge 2", cell_pin, 2'b00);
    @(posedge clk);
    #1 check("R8 runs edge 3", cell_pin, 2'b01);

    // R3 / R4 on a stand-alone cell
    @(negedge clk);
    c_set = 1'b1; c_clr = 1'b0;
    @(posedge clk);
    #1 check("R4 set only", {1'b0, c_pin}, 2'b01);
    @(negedge clk);
    c_clr = 1'b1; c_sel = 1'b0;
    #1 check("R3/R6 next with both", {1'b0, c_pin}, 2'b01);
    c_sel = 1'b1;
    @(posedge clk);
    #1 check("R3 both hold 1", {1'b0, c_pin}, 2'b01);
    @(negedge clk);
    c_set = 1'b0;
    @(posedge clk);
    #1 check("R4 clear only", {1'b0, c_pin}, 2'b00);
    @(negedge clk);
    c_set = 1'b1;
    @(posedge clk);
    #1 check("R3 both hold 0", {1'b0, c_pin}, 2'b00);
    @(negedge clk);
    c_set = 1'b0; c_clr = 1'b0;
    @(posedge clk);
    #1 check("R4 neither holds 0", {1'b0, c_pin}, 2'b00);
    @(negedge clk);
    c_set = 1'b1;
    @(posedge clk);
    @(negedge clk);
    c_set = 1'b0;
    @(posedge clk);
    #1 check("R4 neither holds 1", {1'b0, c_pin}, 2'b01);
    c_oe = 1'b0;
    #1 check("R7 cell pin off", {1'b0, c_pin}, 2'b00);
    check("R7 cell bit kept", {1'b0, c_q}, 2'b01);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule